// File: doc/BRIEF.md
# SYSREF-Aligned Multiframe Clock Generator

This block produces the local multiframe clock for a serial converter link as a single-cycle pulse in the fabric clock domain. The pulse repeats every programmable number of fabric cycles. A free-running counter sets the rate. When the generator is enabled, the counter is pulled back into phase by the rising edge of an external SYSREF signal. The SYSREF signal is first brought into the fabric clock domain through a two-flop synchronizer.

Software controls the block through a 32-bit register port with two addresses. Address 0 holds the period field, a disable bit and a sticky alignment status bit. Address 1 holds a self-clearing request bit. Writing 1 to that bit makes the block ask an external clock chip for one SYSREF pulse.

Top module: `lmfc_align`

## Requirements
- R1: After reset, address 0 reads 0x09800040: period field 19, disable bit 6 set, status bit 7 clear. Address 1 reads 0. `lmfcPulse` and `sysrefReq` are low.
- R2: Bits 31:23 of address 0 hold the divider minus one, and they read back as written.
- R3: While enabled (bit 6 = 0), `lmfcPulse` is high for one cycle out of every (field+1) cycles. After the write that enables the block, the first pulse appears (field+1) cycles later.
- R4: While bit 6 = 1, `lmfcPulse` stays low and SYSREF edges are ignored, so no alignment takes place.
- R5: `sysrefIn` goes through a two-flop synchronizer. If `sysrefIn` rises before clock edge A while the block is enabled, `lmfcPulse` is high in the cycle after edge A+2. After that, it repeats every (field+1) cycles.
- R6: Only a rising edge realigns the counter. Holding `sysrefIn` high does not disturb the pulse spacing.
- R7: Status bit 7 of address 0 becomes 1 after an alignment. Any write to address 0 with bit 6 = 1 clears it.
- R8: Writing address 1 with bit 30 set drives `sysrefReq` high for exactly the one cycle after the write edge. Bit 30 of address 1 reads 1 in that cycle and 0 after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 = capture control, 1 = sync request |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for the selected address (combinational) |
| sysrefIn | input | 1 | Asynchronous SYSREF input |
| lmfcPulse | output | 1 | Single-cycle multiframe clock pulse |
| sysrefReq | output | 1 | One-cycle SYSREF request to the external clock chip |

## Verification
The assertions assume the register port carries only one write per cycle. They also assume that `sysrefIn` changes slowly compared with the clock, so the synchronizer sees each level for several cycles. The stimulus changes `sysrefIn` and the write strobes only on falling clock edges. It holds each SYSREF level for many cycles and never issues two request writes back to back. Because of this, every request write produces its own separate request pulse.

// File: rtl/lmfc_pkg.sv
package lmfc_pkg;
  typedef struct packed {
    logic run;    // generator enabled
    logic align;  // realign counter this cycle
  } lmfcStrb_t;
endpackage

// File: rtl/lmfc_ctrl.sv
module lmfc_ctrl
  import lmfc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int PERIOD_LSB  = 23,
  parameter int DIS_BIT     = 6,
  parameter int STAT_BIT    = 7,
  parameter int REQ_BIT     = 30,
  parameter int SYNC_STAGES = 2,
  parameter int DEF_DIV_M1  = 19,
  localparam int PERIOD_W   = DATA_W - PERIOD_LSB
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                regWrEn,
  input  logic                regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  input  logic                sysrefIn,
  output logic [PERIOD_W-1:0] periodM1,
  output lmfcStrb_t           strb,
  output logic                sysrefReq
);
  logic                 disableBit;
  logic                 alignedFlag;
  logic [SYNC_STAGES:0] syncPipe;
  logic                 ctrlWr, reqWr, sysrefEdge;

  assign ctrlWr = regWrEn && !regAddr;
  assign reqWr  = regWrEn && regAddr && regWrData[REQ_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      periodM1    <= PERIOD_W'(DEF_DIV_M1);
      disableBit  <= 1'b1;
      alignedFlag <= 1'b0;
      sysrefReq   <= 1'b0;
      syncPipe    <= '0;
    end else begin
      syncPipe  <= {syncPipe[SYNC_STAGES-1:0], sysrefIn};
      sysrefReq <= reqWr;
      if (ctrlWr) begin
        periodM1   <= regWrData[PERIOD_LSB +: PERIOD_W];
        disableBit <= regWrData[DIS_BIT];
      end
      if (ctrlWr && regWrData[DIS_BIT]) alignedFlag <= 1'b0;
      else if (strb.align)              alignedFlag <= 1'b1;
    end
  end

  assign sysrefEdge = syncPipe[SYNC_STAGES-1] && !syncPipe[SYNC_STAGES];
  assign strb.run   = !disableBit;
  assign strb.align = !disableBit && sysrefEdge;

  always_comb begin
    regRdData = '0;
    if (!regAddr) begin
      regRdData[PERIOD_LSB +: PERIOD_W] = periodM1;
      regRdData[DIS_BIT]                = disableBit;
      regRdData[STAT_BIT]               = alignedFlag;
    end else begin
      regRdData[REQ_BIT] = sysrefReq;
    end
  end

  // R8
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr && regWrData[REQ_BIT]) |=> sysrefReq);
  // R8
  req_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !(regWrEn && regAddr && regWrData[REQ_BIT]) |=> !sysrefReq);
  // R7
  aligned_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && !regAddr && regWrData[DIS_BIT]) |=> !alignedFlag);
endmodule

// File: rtl/lmfc_count.sv
module lmfc_count
  import lmfc_pkg::*;
#(
  parameter int PERIOD_W = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  lmfcStrb_t           strb,
  input  logic [PERIOD_W-1:0] periodM1,
  output logic                lmfcPulse
);
  logic [PERIOD_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !strb.run) begin
      cnt       <= '0;
      lmfcPulse <= 1'b0;
    end else if (strb.align || cnt >= periodM1) begin
      cnt       <= '0;
      lmfcPulse <= 1'b1;
    end else begin
      cnt       <= cnt + 1'b1;
      lmfcPulse <= 1'b0;
    end
  end

  // R4
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.run |=> !lmfcPulse);
  // R5
  align_chk: assert property (@(posedge clk) disable iff (rst)
    strb.align |=> (lmfcPulse && cnt == '0));
endmodule

// File: rtl/lmfc_align.sv
module lmfc_align
  import lmfc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int PERIOD_LSB  = 23,
  parameter int DIS_BIT     = 6,
  parameter int STAT_BIT    = 7,
  parameter int REQ_BIT     = 30,
  parameter int SYNC_STAGES = 2,
  parameter int DEF_DIV_M1  = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              sysrefIn,
  output logic              lmfcPulse,
  output logic              sysrefReq
);
  localparam int PERIOD_W = DATA_W - PERIOD_LSB;

  lmfcStrb_t           strb;
  logic [PERIOD_W-1:0] periodM1;

  lmfc_ctrl #(
    .DATA_W(DATA_W), .PERIOD_LSB(PERIOD_LSB), .DIS_BIT(DIS_BIT),
    .STAT_BIT(STAT_BIT), .REQ_BIT(REQ_BIT), .SYNC_STAGES(SYNC_STAGES),
    .DEF_DIV_M1(DEF_DIV_M1)
  ) u_ctrl (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .sysrefIn(sysrefIn),
    .periodM1(periodM1), .strb(strb), .sysrefReq(sysrefReq)
  );

  lmfc_count #(.PERIOD_W(PERIOD_W)) u_count (
    .clk(clk), .rst(rst), .strb(strb), .periodM1(periodM1),
    .lmfcPulse(lmfcPulse)
  );
endmodule

// File: tb/tb_lmfc_align.sv
module tb_lmfc_align;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWrEn = 1'b0;
  logic        regAddr = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        sysrefIn = 1'b0;
  logic        lmfcPulse, sysrefReq;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  lmfc_align dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // write at the next rising edge, return 1 ns after it
  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  function automatic logic [31:0] capVal(input int div, input bit dis);
    return (32'(div - 1) << 23) | (dis ? 32'h40 : 32'h0);
  endfunction

  // counts cycles whose pulse differs from the expected pattern
  task automatic pulseWindow(input string req, input int n, input int first, input int div, output int bad);
    bad = 0;
    for (int i = 1; i <= n; i++) begin
      logic e;
      @(posedge clk); #1;
      e = (div > 0) && (i >= first) && ((i - first) % div == 0);
      if (lmfcPulse !== e) bad++;
    end
  endtask

  task automatic testReset();
    regAddr = 1'b0; #1;
    check("R1 addr0", regRdData, 32'h0980_0040);
    check("R1 pulse", {31'b0, lmfcPulse}, 0);
    check("R1 req", {31'b0, sysrefReq}, 0);
    regAddr = 1'b1; #1;
    check("R1 addr1", regRdData, 0);
  endtask

  task automatic testDisabled();
    int bad;
    wr(1'b0, capVal(8, 1'b1));
    regAddr = 1'b0; #1;
    check("R2 readback", regRdData, capVal(8, 1'b1));
    @(negedge clk) sysrefIn = 1'b1;
    pulseWindow("R4", 30, 0, 0, bad);
    check("R4 no pulse while disabled", bad, 0);
    check("R4 no alignment while disabled", regRdData[7], 0);
    @(negedge clk) sysrefIn = 1'b0;
    repeat (5) @(posedge clk);
  endtask

  task automatic testPeriod(input int div);
    int bad;
    wr(1'b0, capVal(div, 1'b1));
    wr(1'b0, capVal(div, 1'b0));
    pulseWindow("R3", 3 * div, div, div, bad);
    check($sformatf("R3 spacing div=%0d", div), bad, 0);
  endtask

  task automatic testAlign(input int div);
    int bad;
    wr(1'b0, capVal(div, 1'b0));
    repeat (div / 2 + 1) @(posedge clk);
    @(negedge clk) sysrefIn = 1'b1;
    bad = 0;
    for (int i = 1; i <= 3 + 3 * div; i++) begin
      @(posedge clk); #1;
      if (i >= 3 && lmfcPulse !== ((i - 3) % div == 0)) bad++;
    end
    check($sformatf("R5 realign div=%0d", div), bad, 0);
    pulseWindow("R6", 2 * div, div - 3 * div % div, div, bad);
    check("R6 level held high does not realign", bad, 0);
    regAddr = 1'b0; #1;
    check("R7 status set", regRdData[7], 1);
    @(negedge clk) sysrefIn = 1'b0;
    wr(1'b0, capVal(div, 1'b1));
    regAddr = 1'b0; #1;
    check("R7 status cleared by disable write", regRdData[7], 0);
  endtask

  task automatic testReq();
    wr(1'b1, 32'h4000_0000);
    regAddr = 1'b1; #1;
    check("R8 req high", {31'b0, sysrefReq}, 1);
    check("R8 readback during", regRdData, 32'h4000_0000);
    @(posedge clk); #1;
    check("R8 req one cycle", {31'b0, sysrefReq}, 0);
    check("R8 readback after", regRdData, 0);
    wr(1'b1, 32'h0000_0001);
    check("R8 other bits no request", {31'b0, sysrefReq}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    testReset();
    testDisabled();
    testPeriod(20);
    testPeriod(5);
    testPeriod(2);
    testAlign(20);
    testAlign(7);
    testReq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule